// File: doc/BRIEF.md
# Multi-Size Double-Width Unsigned Divider

This block divides an unsigned dividend of twice the operand width by a divisor of the operand width. The operand width is chosen for each operation by a two-bit size code: 8, 16, 32 or 64 bits. A caller presents a high half, a low half, a divisor and the size code, and pulses `start` while the block is idle. One setup cycle checks the operands. Then a restoring shift-subtract loop produces one quotient bit per cycle. A single-cycle `done` pulse marks the end of the operation.

The quotient goes to the low result register and the remainder to the high result register. Byte mode is different: the dividend is one 16-bit value, and the quotient and remainder are packed into the low 16 bits of the low result register. Some operations have no valid result: a zero divisor, a quotient too wide for the operand width, or a 64-bit request outside long mode. These end after the setup cycle with `div_err` raised alongside `done`, and the result registers are not touched. The arithmetic flag outputs carry no defined meaning.

Top module: `dwdiv`

## Requirements
- R1: For size codes 2'b01 (16 bit), 2'b10 (32 bit) and 2'b11 (64 bit), the divisor is `dvsr_in[N-1:0]` and the dividend is `{hi_in[N-1:0], lo_in[N-1:0]}`. A successful operation sets `res_lo` to the quotient truncated toward zero and `res_hi` to the remainder, both zero-extended to 64 bits. The remainder is always below the divisor.
- R2: For size code 2'b00 (8 bit), the dividend is `lo_in[15:0]` and the divisor is `dvsr_in[7:0]`. On success `res_lo[7:0]` takes the quotient and `res_lo[15:8]` the remainder. `res_lo[63:16]` and all of `res_hi` keep their previous values.
- R3: When the true quotient exceeds the operand-width maximum (0xFF, 0xFFFF, 0xFFFFFFFF or all ones over 64 bits), `div_err` is raised with `done`, and `res_lo` and `res_hi` keep their previous values.
- R4: A divisor of zero over the operand width raises `div_err` with `done` and leaves both result registers unchanged.
- R5: Size code 2'b11 while `long_mode` is low is an error: `div_err` is raised with `done` and the results are unchanged. With `long_mode` high the same code divides normally.
- R6: `done` is a one-cycle pulse. It appears N+1 clock edges after the edge that accepts `start` on success, and 1 edge after on error. `busy` is high from the cycle after acceptance until `done` appears.
- R7: `start` and all operand inputs are ignored while `busy` is high. They have no effect on the result of the running operation.
- R8: Input bits above the operand width (above bit 15 of `lo_in` and above bit 7 of `dvsr_in` in byte mode, and all of `hi_in` in byte mode) have no effect on the result.
- R9: After reset, `busy`, `done` and `div_err` are low, and `res_lo` and `res_hi` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| size_sel | input | 2 | Operand width code: 00=8, 01=16, 10=32, 11=64 |
| long_mode | input | 1 | Permits the 64-bit size code |
| hi_in | input | 64 | High half of the dividend |
| lo_in | input | 64 | Low half of the dividend (whole 16-bit dividend in byte mode) |
| dvsr_in | input | 64 | Divisor |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Divide error, valid with done |
| res_lo | output | 64 | Quotient (byte mode: remainder and quotient in bits 15:0) |
| res_hi | output | 64 | Remainder (untouched in byte mode) |
| flags_out | output | 6 | Arithmetic flags, undefined value |

## Verification
The vector table exercises every size code with ordinary operands. It also covers a divisor larger than the dividend, which gives a zero quotient, and a dividend equal to the divisor. These cases separate correct quotient and remainder routing from swapped or misaligned halves. Random operands at each size hold the high half below the divisor, with an occasional unconstrained one, and carry junk above the operand width. This separates correct masking from leakage of upper bits and exposes the boundary between success and overflow. Directed cases check the remaining boundaries: divisor one, divisor zero, high half equal to the divisor, the largest quotient that still fits, the 64-bit code with and without long mode, and a second start issued mid-operation. Each of these has an exact expected outcome and latency.

// File: rtl/dwdiv_pkg.sv
package dwdiv_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned CNT_W = $clog2(XLEN + 1);
  localparam int unsigned FLG_W = 6;

  typedef enum logic [1:0] {
    SZ8  = 2'b00,
    SZ16 = 2'b01,
    SZ32 = 2'b10,
    SZ64 = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SETUP = 2'b01,
    ST_RUN   = 2'b10
  } state_e;
endpackage

// File: rtl/dwdiv_prep.sv
module dwdiv_prep
  import dwdiv_pkg::*;
(
  input  size_e                  sz,
  input  logic                   lm,
  input  logic [XLEN-1:0]        hi,
  input  logic [XLEN-1:0]        lo,
  input  logic [XLEN-1:0]        dv,
  output logic [XLEN-1:0]        hh,
  output logic [XLEN-1:0]        ll_al,
  output logic [XLEN-1:0]        dd,
  output logic [CNT_W-1:0]       nbits,
  output logic                   err
);
  logic illegal;

  always_comb begin
    illegal = 1'b0;
    case (sz)
      SZ8: begin
        hh    = {{(XLEN-8){1'b0}}, lo[15:8]};
        ll_al = {lo[7:0], {(XLEN-8){1'b0}}};
        dd    = {{(XLEN-8){1'b0}}, dv[7:0]};
        nbits = CNT_W'(8);
      end
      SZ16: begin
        hh    = {{(XLEN-16){1'b0}}, hi[15:0]};
        ll_al = {lo[15:0], {(XLEN-16){1'b0}}};
        dd    = {{(XLEN-16){1'b0}}, dv[15:0]};
        nbits = CNT_W'(16);
      end
      SZ32: begin
        hh    = {{(XLEN-32){1'b0}}, hi[31:0]};
        ll_al = {lo[31:0], {(XLEN-32){1'b0}}};
        dd    = {{(XLEN-32){1'b0}}, dv[31:0]};
        nbits = CNT_W'(32);
      end
      default: begin
        hh      = hi;
        ll_al   = lo;
        dd      = dv;
        nbits   = CNT_W'(XLEN);
        illegal = !lm;
      end
    endcase
    // high half not below the divisor means the quotient cannot fit;
    // a zero divisor always falls into this case
    err = illegal || (hh >= dd);
  end
endmodule

// File: rtl/dwdiv_step.sv
module dwdiv_step
  import dwdiv_pkg::*;
(
  input  logic [XLEN-1:0] rem_in,
  input  logic            bit_in,
  input  logic [XLEN-1:0] dd,
  output logic [XLEN-1:0] rem_out,
  output logic            qbit
);
  logic [XLEN:0]   trial;
  logic [XLEN-1:0] diff;

  always_comb begin
    trial   = {rem_in, bit_in};
    diff    = trial[XLEN-1:0] - dd;
    qbit    = (trial >= {1'b0, dd});
    rem_out = qbit ? diff : trial[XLEN-1:0];
  end

  // R1: a partial remainder below the divisor stays below it
  always_comb begin
    if ((dd != '0) && (rem_in < dd)) begin
      p_rem_bound_r1: assert (rem_out < dd);
    end
  end
endmodule

// File: rtl/dwdiv.sv
module dwdiv
  import dwdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       size_sel,
  input  logic             long_mode,
  input  logic [XLEN-1:0]  hi_in,
  input  logic [XLEN-1:0]  lo_in,
  input  logic [XLEN-1:0]  dvsr_in,
  output logic             busy,
  output logic             done,
  output logic             div_err,
  output logic [XLEN-1:0]  res_lo,
  output logic [XLEN-1:0]  res_hi,
  output logic [FLG_W-1:0] flags_out
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  state_e          st_q, st_n;
  size_e           cap_sz;
  logic            cap_lm;
  logic [XLEN-1:0] cap_hi, cap_lo, cap_dv;
  logic            cap_en;
  logic [XLEN-1:0] rem_q, rem_n, qsr_q, qsr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic            done_q, done_n, err_q, err_n;
  logic            res_en;
  logic [XLEN-1:0] res_lo_q, res_lo_n, res_hi_q, res_hi_n;

  logic [XLEN-1:0]  pre_hh, pre_ll, pre_dd;
  logic [CNT_W-1:0] pre_n;
  logic             pre_err;
  logic [XLEN-1:0]  stp_rem;
  logic             stp_bit;

  dwdiv_prep u_prep (
    .sz    (cap_sz),
    .lm    (cap_lm),
    .hi    (cap_hi),
    .lo    (cap_lo),
    .dv    (cap_dv),
    .hh    (pre_hh),
    .ll_al (pre_ll),
    .dd    (pre_dd),
    .nbits (pre_n),
    .err   (pre_err)
  );

  dwdiv_step u_step (
    .rem_in  (rem_q),
    .bit_in  (qsr_q[XLEN-1]),
    .dd      (pre_dd),
    .rem_out (stp_rem),
    .qbit    (stp_bit)
  );

  // next-state logic
  always_comb begin
    st_n     = st_q;
    cap_en   = 1'b0;
    rem_n    = rem_q;
    qsr_n    = qsr_q;
    cnt_n    = cnt_q;
    done_n   = 1'b0;
    err_n    = 1'b0;
    res_en   = 1'b0;
    res_lo_n = res_lo_q;
    res_hi_n = res_hi_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          cap_en = 1'b1;
          st_n   = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (pre_err) begin
          done_n = 1'b1;
          err_n  = 1'b1;
          st_n   = ST_IDLE;
        end else begin
          rem_n = pre_hh;
          qsr_n = pre_ll;
          cnt_n = pre_n;
          st_n  = ST_RUN;
        end
      end
      ST_RUN: begin
        rem_n = stp_rem;
        qsr_n = {qsr_q[XLEN-2:0], stp_bit};
        cnt_n = CNT_W'(cnt_q - 1'b1);
        if (cnt_q == CNT_W'(1)) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
          res_en = 1'b1;
          if (cap_sz == SZ8) begin
            res_lo_n = {res_lo_q[XLEN-1:16], stp_rem[7:0], qsr_n[7:0]};
          end else begin
            res_lo_n = qsr_n;
            res_hi_n = stp_rem;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q     <= ST_IDLE;
      cap_sz   <= SZ8;
      cap_lm   <= 1'b0;
      cap_hi   <= '0;
      cap_lo   <= '0;
      cap_dv   <= '0;
      rem_q    <= '0;
      qsr_q    <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      res_lo_q <= '0;
      res_hi_q <= '0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      err_q  <= err_n;
      rem_q  <= rem_n;
      qsr_q  <= qsr_n;
      cnt_q  <= cnt_n;
      if (cap_en) begin
        cap_sz <= size_e'(size_sel);
        cap_lm <= long_mode;
        cap_hi <= hi_in;
        cap_lo <= lo_in;
        cap_dv <= dvsr_in;
      end
      if (res_en) begin
        res_lo_q <= res_lo_n;
        res_hi_q <= res_hi_n;
      end
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign div_err   = err_q;
  assign res_lo    = res_lo_q;
  assign res_hi    = res_hi_q;
  assign flags_out = '0;

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done);
  // R6: error only reported together with completion, and never while busy
  p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    div_err |-> (done && !busy));
  // R4: zero divisor ends the setup cycle with an error
  p_zero_div_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_SETUP && pre_dd == '0) |=> (done && div_err));
  // R5: 64-bit code outside long mode is rejected
  p_illegal_size_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_SETUP && cap_sz == SZ64 && !cap_lm) |=> (done && div_err));
  // R3: an error leaves the result registers untouched
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && div_err) |-> ($stable(res_lo) && $stable(res_hi)));
  // R1: remainder below divisor on success
  p_rem_lt_div_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && !div_err && cap_sz != SZ8) |-> (res_hi < pre_dd));
  // R2: byte mode keeps the bits it does not own
  p_byte_keep_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && !div_err && cap_sz == SZ8) |->
      ($stable(res_hi) && $stable(res_lo[XLEN-1:16]) &&
       ({56'b0, res_lo[15:8]} < pre_dd)));
  // R7: captured operands cannot change while busy
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && start) |=> ($stable(cap_sz) && $stable(cap_dv) &&
                         $stable(cap_hi) && $stable(cap_lo)));
endmodule

// File: tb/sim_dwdiv.sv
`timescale 1ns/1ps
module sim_dwdiv;
  typedef struct packed {
    logic [1:0]  sz;
    logic        lm;
    logic [63:0] hi;
    logic [63:0] lo;
    logic [63:0] dv;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{2'd1, 1'b0, 64'h1,                64'h2345,              64'hF0},
    '{2'd2, 1'b0, 64'h12,               64'h89ABCDEF,          64'h1000},
    '{2'd3, 1'b1, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210,  64'h0FEDCBA987654321},
    '{2'd0, 1'b0, 64'h0,                64'h1234,              64'h55},
    '{2'd0, 1'b0, 64'h0,                64'hFFFF,              64'h1},
    '{2'd1, 1'b0, 64'h0,                64'h7,                 64'h7},
    '{2'd2, 1'b0, 64'h0,                64'h5,                 64'h9},
    '{2'd3, 1'b0, 64'h1,                64'h2,                 64'h3},
    '{2'd1, 1'b0, 64'hABCD,             64'h0,                 64'hABCD},
    '{2'd2, 1'b0, 64'hFFFFFFFE,         64'hFFFFFFFF,          64'hFFFFFFFF},
    '{2'd0, 1'b0, 64'h0,                64'h00FF,              64'hFF},
    '{2'd1, 1'b0, 64'hDEAD000000000003, 64'hBEEF000000000010,  64'h1234000000000005}
  };

  logic        clk, rst_n, start, long_mode;
  logic [1:0]  size_sel;
  logic [63:0] hi_in, lo_in, dvsr_in;
  logic        busy, done, div_err;
  logic [63:0] res_lo, res_hi;
  logic [5:0]  flags_out;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [63:0] mdl_lo, mdl_hi;

  dwdiv u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
    .long_mode(long_mode), .hi_in(hi_in), .lo_in(lo_in), .dvsr_in(dvsr_in),
    .busy(busy), .done(done), .div_err(div_err), .res_lo(res_lo),
    .res_hi(res_hi), .flags_out(flags_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: run hung act=%0d exp<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference from the requirements
  task automatic model(input vec_t v, output logic e_err, output int n);
    logic [63:0]  mask, hh, ll, dd;
    logic [127:0] dvd, q, r;
    logic         illegal;
    case (v.sz)
      2'd0: n = 8;
      2'd1: n = 16;
      2'd2: n = 32;
      default: n = 64;
    endcase
    mask    = (n == 64) ? {64{1'b1}} : ((64'd1 << n) - 64'd1);
    illegal = (v.sz == 2'd3) && !v.lm;
    if (v.sz == 2'd0) begin
      hh = {56'b0, v.lo[15:8]};
      ll = {56'b0, v.lo[7:0]};
      dd = {56'b0, v.dv[7:0]};
    end else begin
      hh = v.hi & mask;
      ll = v.lo & mask;
      dd = v.dv & mask;
    end
    dvd = ({64'b0, hh} << n) | {64'b0, ll};
    q = '0;
    r = '0;
    if (illegal || dd == 64'd0) begin
      e_err = 1'b1;
    end else begin
      q     = dvd / {64'b0, dd};
      r     = dvd % {64'b0, dd};
      e_err = (q > {64'b0, mask});
    end
    if (!e_err) begin
      if (v.sz == 2'd0) mdl_lo[15:0] = {r[7:0], q[7:0]};
      else begin
        mdl_lo = q[63:0];
        mdl_hi = r[63:0];
      end
    end
  endtask

  task automatic op(input vec_t v, input string tag, input bit poke);
    logic e_err;
    int   n, cnt, exp_lat;
    model(v, e_err, n);
    exp_lat = e_err ? 1 : n + 1;
    @(negedge clk);
    size_sel = v.sz; long_mode = v.lm;
    hi_in = v.hi; lo_in = v.lo; dvsr_in = v.dv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({"R6 busy after accept ", tag}, {63'b0, busy}, 64'd1);
    cnt = 0;
    while (!done && cnt < 200) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 2) begin
        start = 1'b1; size_sel = 2'd1; long_mode = 1'b0;
        hi_in = 64'h0; lo_in = 64'h1; dvsr_in = 64'h1;
      end else if (poke && cnt == 3) begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk({"R6 latency ", tag}, 64'(cnt), 64'(exp_lat));
    chk({"R6 busy low at done ", tag}, {63'b0, busy}, 64'd0);
    chk({"R3 error flag ", tag}, {63'b0, div_err}, {63'b0, e_err});
    chk({"res_lo ", tag}, res_lo, mdl_lo);
    chk({"res_hi ", tag}, res_hi, mdl_hi);
    @(negedge clk);
    chk({"R6 done pulse ", tag}, {63'b0, done}, 64'd0);
  endtask

  initial begin
    vec_t v;
    rst_n = 1'b0; start = 1'b0; size_sel = 2'd0; long_mode = 1'b0;
    hi_in = '0; lo_in = '0; dvsr_in = '0;
    mdl_lo = '0; mdl_hi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    chk("R9 busy", {63'b0, busy}, 64'd0);
    chk("R9 done", {63'b0, done}, 64'd0);
    chk("R9 div_err", {63'b0, div_err}, 64'd0);
    chk("R9 res_lo", res_lo, 64'd0);
    chk("R9 res_hi", res_hi, 64'd0);

    // vector table: R1 for wide sizes, R2 for byte size
    for (int i = 0; i < NV; i++) begin
      op(VT[i], (VT[i].sz == 2'd0) ? "R2 table" : "R1 table", 1'b0);
    end

    // R1 divisor one
    v = '{2'd2, 1'b0, 64'h0, 64'hCAFEF00D, 64'h1};
    op(v, "R1 divisor one", 1'b0);
    // R4 divisor zero at each size
    for (int s = 0; s < 4; s++) begin
      v = '{2'(s), 1'b1, 64'h0, 64'h1234, 64'hFFFF_FFFF_0000_0000 & ~((s == 3) ? 64'hFFFF_FFFF_0000_0000 : 64'h0)};
      op(v, "R4 zero divisor", 1'b0);
    end
    // R3 high half equal to divisor
    v = '{2'd3, 1'b1, 64'h8000000000000000, 64'h0, 64'h8000000000000000};
    op(v, "R3 hi equals divisor", 1'b0);
    // R1 largest quotient that fits
    v = '{2'd3, 1'b1, 64'hFFFFFFFFFFFFFFFE, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF};
    op(v, "R1 max quotient", 1'b0);
    // R5 64-bit code with and without long mode
    v = '{2'd3, 1'b0, 64'h0, 64'h64, 64'h7};
    op(v, "R5 no long mode", 1'b0);
    v = '{2'd3, 1'b1, 64'h0, 64'h64, 64'h7};
    op(v, "R5 long mode", 1'b0);
    // R7 start during busy is ignored
    v = '{2'd2, 1'b0, 64'h3, 64'h12345678, 64'h10};
    op(v, "R7 start while busy", 1'b1);
    // R8 junk above byte width
    v = '{2'd0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 64'hA5A5A5A5A5A50C80, 64'hFFFFFFFFFFFFFF21};
    op(v, "R8 byte junk", 1'b0);

    // random operands at every size, junk above width (R8)
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 30; k++) begin
        v.sz = 2'(s);
        v.lm = 1'b1;
        v.hi = {$urandom(), $urandom()};
        v.lo = {$urandom(), $urandom()};
        v.dv = {$urandom(), $urandom()};
        if (v.dv[7:0] == 8'd0) v.dv[0] = 1'b1;
        if ((k % 8) != 7) begin
          case (s)
            0: v.lo[15:8]  = v.lo[15:8] % v.dv[7:0];
            1: v.hi[15:0]  = v.hi[15:0] % v.dv[15:0];
            2: v.hi[31:0]  = v.hi[31:0] % v.dv[31:0];
            default: v.hi  = v.hi % v.dv;
          endcase
        end
        op(v, (s == 0) ? "R2 R8 random" : "R1 R8 random", 1'b0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule